// File: doc/BRIEF.md
# Destination Address Filter with Station Table

The block decides, for every frame the receive path presents, whether that frame is kept or dropped. The decision uses only the frame's 48-bit destination address. The receive path supplies the address together with a one-cycle strobe. One clock later the block returns a keep/drop verdict. It also returns a flag showing whether a table entry matched, and the number of that entry.

The decision has two inputs. The first is a table of station addresses, and each table entry can be switched on or off. The second is a small command word that selects which classes of frame are kept outright: every unicast frame, every multicast frame, or broadcast frames. Another command bit inverts the sense of the table match, and a compare-enable bit must be set before any frame is kept at all. Software loads the table, the per-entry switches and the command word through a write-only, word-addressed register port. The register offsets match the layout the receive path's driver expects.

Top module: `dst_filter`

## Requirements
- R1: After reset the table, every entry switch and the command word are zero, `res_valid` is low, and every frame that arrives before software writes any register is dropped.
- R2: Each cycle with `dst_valid` high yields exactly one cycle with `res_valid` high, on the following cycle. Back-to-back strobes give back-to-back results.
- R3: The upper word of entry x sits at byte offset 0x08+8x and holds address bytes 0..3, with byte 0 (the first byte on the wire, `dst_addr[47:40]`) in bits 31:24. The lower word sits at 0x0C+8x and holds bytes 4 and 5 in bits 31:16. Its bits 15:0 have no effect.
- R4: The switch register at offset 0x04 has bit x enabling entry x. An entry whose switch is clear never matches.
- R5: When several enabled entries match, `res_hit` is 1 and `res_index` names the lowest-numbered one. When none match, `res_hit` and `res_index` are both 0.
- R6: The command word is at offset 0x00, and bit 4 is compare-enable. While bit 4 is 0, every frame is dropped, whatever the other bits say.
- R7: With bits 4 and 2 set, a frame whose destination is all ones (broadcast) is kept.
- R8: With bits 4 and 1 set, a frame with `dst_addr[40]` set that is not broadcast (multicast) is kept.
- R9: With bits 4 and 0 set, every frame with `dst_addr[40]` clear (unicast) is kept.
- R10: Bit 3 inverts the table-match term. With bit 3 set, a frame that matches no enabled entry is kept, and a frame that matches is kept only if a class bit keeps it.
- R11: A register write in the same cycle as `dst_valid` does not affect that frame's verdict. It applies from the next frame on.
- R12: Writes have no effect when the offset is not a multiple of 4 or lies beyond the last table word (0x84 for 16 entries).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Byte offset of the register written |
| wr_data | input | 32 | Write data |
| dst_valid | input | 1 | Destination address strobe from the receive path |
| dst_addr | input | 48 | Destination address, first wire byte in bits 47:40 |
| res_valid | output | 1 | Verdict valid, one cycle after `dst_valid` |
| res_accept | output | 1 | 1 = keep the frame, 0 = drop it |
| res_hit | output | 1 | An enabled entry matched |
| res_index | output | 4 | Lowest matching entry, 0 when there is no hit |

## Verification
The case hardest to reach from the ports is a register write landing in the same cycle as the address strobe, because the frame must still be judged against the old configuration. The stimulus fires a write that disables the matching entry in exactly the cycle the matching address is presented, then presents the address again. Two entries are loaded with the same address and their switches are toggled, so the lowest-index priority is exercised. Misaligned and out-of-range writes are aimed at offsets that would land on entry 0 or on the command word if the decode wrapped or ignored the low address bits.

// File: rtl/dst_filter_pkg.sv
`timescale 1ns/1ps
package dst_filter_pkg;
  localparam int unsigned MAC_W  = 48;
  localparam int unsigned CMD_W  = 5;
  // command bit positions (software decodes these)
  localparam int unsigned C_ALL_UC = 0;
  localparam int unsigned C_ALL_MC = 1;
  localparam int unsigned C_BCAST  = 2;
  localparam int unsigned C_INVERT = 3;
  localparam int unsigned C_CMPEN  = 4;
  // position of the group bit: bit 0 of the first wire byte
  localparam int unsigned GROUP_BIT = MAC_W - 8;

  function automatic logic addr_is_bcast(input logic [MAC_W-1:0] a);
    return &a;
  endfunction

  function automatic logic addr_is_mcast(input logic [MAC_W-1:0] a);
    return a[GROUP_BIT] & ~(&a);
  endfunction

  function automatic logic [MAC_W-1:0] join_entry(input logic [31:0] hi,
                                                  input logic [15:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/dst_filter_regs.sv
`timescale 1ns/1ps
module dst_filter_regs
  import dst_filter_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [AW-1:0]                   wr_addr,
  input  logic [DW-1:0]                   wr_data,
  output logic [CMD_W-1:0]                cmd,
  output logic [N_ENTRIES-1:0]            en_mask,
  output logic [N_ENTRIES-1:0][MAC_W-1:0] table_q
);
  localparam int unsigned WI    = AW - 2;
  localparam int unsigned WORDS = 2 + 2 * N_ENTRIES;

  logic [WI-1:0] word;
  logic          wr_ok;

  assign word  = wr_addr[AW-1:2];
  assign wr_ok = wr_en && (wr_addr[1:0] == 2'b00) && (int'(word) < WORDS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd     <= '0;
      en_mask <= '0;
    end else if (wr_ok) begin
      if (word == WI'(0)) cmd     <= wr_data[CMD_W-1:0];
      if (word == WI'(1)) en_mask <= wr_data[N_ENTRIES-1:0];
    end
  end

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    logic [31:0] hi_q;
    logic [15:0] lo_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hi_q <= '0;
        lo_q <= '0;
      end else if (wr_ok) begin
        if (word == WI'(2 + 2 * g)) hi_q <= wr_data[31:0];
        if (word == WI'(3 + 2 * g)) lo_q <= wr_data[31:16];
      end
    end
    assign table_q[g] = join_entry(hi_q, lo_q);
  end
endmodule

// File: rtl/dst_filter_match.sv
`timescale 1ns/1ps
module dst_filter_match
  import dst_filter_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IW       = $clog2(N_ENTRIES)
) (
  input  logic [MAC_W-1:0]                addr,
  input  logic [N_ENTRIES-1:0][MAC_W-1:0] table_q,
  input  logic [N_ENTRIES-1:0]            en_mask,
  output logic                            hit,
  output logic [IW-1:0]                   idx
);
  logic [N_ENTRIES-1:0] eq;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign eq[g] = en_mask[g] && (table_q[g] == addr);
  end

  always_comb begin
    idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) idx = IW'(i);
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/dst_filter_decide.sv
`timescale 1ns/1ps
module dst_filter_decide
  import dst_filter_pkg::*;
#(
  parameter int unsigned IW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             valid,
  input  logic [MAC_W-1:0] addr,
  input  logic [CMD_W-1:0] cmd,
  input  logic             hit,
  input  logic [IW-1:0]    idx,
  output logic             res_valid,
  output logic             res_accept,
  output logic             res_hit,
  output logic [IW-1:0]    res_index
);
  logic is_bc, is_mc, is_uc, class_keep, cam_term, keep;

  assign is_bc      = addr_is_bcast(addr);
  assign is_mc      = addr_is_mcast(addr);
  assign is_uc      = ~addr[GROUP_BIT];
  assign class_keep = (is_uc & cmd[C_ALL_UC]) | (is_mc & cmd[C_ALL_MC]) |
                      (is_bc & cmd[C_BCAST]);
  assign cam_term   = hit ^ cmd[C_INVERT];
  assign keep       = cmd[C_CMPEN] & (class_keep | cam_term);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      res_hit    <= 1'b0;
      res_index  <= '0;
    end else begin
      res_valid  <= valid;
      res_accept <= valid & keep;
      res_hit    <= valid & hit;
      res_index  <= (valid && hit) ? idx : '0;
    end
  end
endmodule

// File: rtl/dst_filter.sv
`timescale 1ns/1ps
module dst_filter
  import dst_filter_pkg::*;
#(
  parameter int unsigned N_ENTRIES = 16,
  parameter int unsigned AW        = 8,
  parameter int unsigned DW        = 32,
  localparam int unsigned IW       = $clog2(N_ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          dst_valid,
  input  logic [47:0]   dst_addr,
  output logic          res_valid,
  output logic          res_accept,
  output logic          res_hit,
  output logic [IW-1:0] res_index
);
  logic [CMD_W-1:0]                cmd_w;
  logic [N_ENTRIES-1:0]            en_mask_w;
  logic [N_ENTRIES-1:0][MAC_W-1:0] table_w;
  logic                            hit_w;
  logic [IW-1:0]                   idx_w;
  logic                            cmp_en_w;

  assign cmp_en_w = cmd_w[C_CMPEN];

  dst_filter_regs #(.N_ENTRIES(N_ENTRIES), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmd(cmd_w), .en_mask(en_mask_w), .table_q(table_w)
  );

  dst_filter_match #(.N_ENTRIES(N_ENTRIES)) u_match (
    .addr(dst_addr), .table_q(table_w), .en_mask(en_mask_w),
    .hit(hit_w), .idx(idx_w)
  );

  dst_filter_decide #(.IW(IW)) u_decide (
    .clk(clk), .rst_n(rst_n), .valid(dst_valid), .addr(dst_addr),
    .cmd(cmd_w), .hit(hit_w), .idx(idx_w), .res_valid(res_valid),
    .res_accept(res_accept), .res_hit(res_hit), .res_index(res_index)
  );
endmodule

// File: rtl/dst_filter_chk.sv
`timescale 1ns/1ps
module dst_filter_chk #(
  parameter int unsigned N_ENTRIES = 16,
  localparam int unsigned IW       = $clog2(N_ENTRIES)
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 dst_valid,
  input logic                 res_valid,
  input logic                 res_accept,
  input logic                 res_hit,
  input logic [IW-1:0]        res_index,
  input logic                 cmp_en,
  input logic [N_ENTRIES-1:0] en_mask
);
  logic [N_ENTRIES-1:0] en_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_seen <= '0;
    else if (dst_valid) en_seen <= en_mask;
  end

  assert_result_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    dst_valid |=> res_valid);
  assert_no_spurious_result_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dst_valid |=> !res_valid);
  assert_cmp_off_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_valid && !cmp_en) |=> !res_accept);
  assert_hit_is_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    res_hit |-> en_seen[res_index]);
  assert_miss_index_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_hit) |-> (res_index == '0));
endmodule

bind dst_filter dst_filter_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .dst_valid(dst_valid), .res_valid(res_valid),
  .res_accept(res_accept), .res_hit(res_hit), .res_index(res_index),
  .cmp_en(cmp_en_w), .en_mask(en_mask_w)
);

// File: tb/dst_filter_tb.sv
`timescale 1ns/1ps
module dst_filter_tb;
  localparam int NENT = 16;
  localparam logic [47:0] BC = 48'hFFFF_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        dst_valid = 1'b0;
  logic [47:0] dst_addr = '0;
  logic        res_valid, res_accept, res_hit;
  logic [3:0]  res_index;

  int checks = 0;
  int errors = 0;

  logic [31:0] sh_hi [NENT];
  logic [31:0] sh_lo [NENT];
  logic [15:0] sh_en = '0;
  logic [4:0]  sh_cmd = '0;

  logic [5:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  dst_filter u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dst_valid(dst_valid), .dst_addr(dst_addr),
    .res_valid(res_valid), .res_accept(res_accept), .res_hit(res_hit),
    .res_index(res_index)
  );

  // reference: verdict {keep, hit, index} derived from the requirements
  function automatic logic [5:0] model(input logic [47:0] a);
    logic h; logic [3:0] ix; logic cls; logic keep;
    h = 1'b0; ix = 4'd0;
    for (int k = 0; k < NENT; k++)
      if (!h && sh_en[k] && ({sh_hi[k], sh_lo[k][31:16]} == a)) begin
        h = 1'b1; ix = k[3:0];
      end
    cls = (a == BC && sh_cmd[2]) || (!a[40] && sh_cmd[0]) ||
          (a[40] && a != BC && sh_cmd[1]);
    keep = sh_cmd[4] && (cls || (h != sh_cmd[3]));
    return {keep, h, ix};
  endfunction

  function automatic void shadow_write(input logic [7:0] a, input logic [31:0] d);
    if (a[1:0] != 2'b00) return;
    if (a == 8'h00) sh_cmd = d[4:0];
    else if (a == 8'h04) sh_en = d[15:0];
    else if (a >= 8'h08 && int'(a) < 8 + 8 * NENT) begin
      if (a[2] == 1'b0) sh_hi[(int'(a) - 8) / 8] = d;
      else              sh_lo[(int'(a) - 8) / 8] = d;
    end
  endfunction

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    dst_valid = 1'b0;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    shadow_write(a, d);
  endtask

  task automatic send(input logic [47:0] a, input string tag);
    @(negedge clk);
    wr_en = 1'b0;
    dst_valid = 1'b1; dst_addr = a;
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
  endtask

  // write and frame in the same cycle: verdict uses the old configuration
  task automatic send_and_write(input logic [47:0] a, input logic [7:0] wa,
                                input logic [31:0] wd, input string tag);
    @(negedge clk);
    dst_valid = 1'b1; dst_addr = a;
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
    wr_en = 1'b1; wr_addr = wa; wr_data = wd;
    shadow_write(wa, wd);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      wr_en = 1'b0; dst_valid = 1'b0;
    end
  endtask

  // monitor: pop and compare every verdict the design produces
  always @(posedge clk) begin
    #1;
    if (rst_n && res_valid) begin
      logic [5:0] e; string t;
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected result actual=%b expected=none",
                 {res_accept, res_hit, res_index});
      end else begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if ({res_accept, res_hit, res_index} !== e) begin
          errors++;
          $display("FAIL %s: actual=%b expected=%b", t,
                   {res_accept, res_hit, res_index}, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int k = 0; k < NENT; k++) begin sh_hi[k] = '0; sh_lo[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (res_valid !== 1'b0 || res_accept !== 1'b0) begin
      errors++;
      $display("FAIL R1: actual=%b%b expected=00", res_valid, res_accept);
    end
    // R1: unconfigured block drops everything
    send(BC, "R1");
    send(48'h0000_0000_0000, "R1");
    idle(1);
    // R3 / R4: entry 3 loaded, low 16 bits of the lower word are junk
    reg_wr(8'h20, 32'h0211_2233);
    reg_wr(8'h24, 32'h4455_ABCD);
    reg_wr(8'h04, 32'h0000_0008);
    reg_wr(8'h00, 32'h0000_0010);
    send(48'h0211_2233_4455, "R3");
    send(48'h0211_2233_4456, "R3");
    send(48'h1102_2233_4455, "R3");
    reg_wr(8'h04, 32'h0000_0000);
    send(48'h0211_2233_4455, "R4");
    // R5: same address in entries 3 and 7
    reg_wr(8'h40, 32'h0211_2233);
    reg_wr(8'h44, 32'h4455_0000);
    reg_wr(8'h04, 32'h0000_0088);
    send(48'h0211_2233_4455, "R5");
    reg_wr(8'h04, 32'h0000_0080);
    send(48'h0211_2233_4455, "R5");
    send(48'h06AA_BBCC_DDEE, "R5");
    // R7 broadcast
    reg_wr(8'h00, 32'h0000_0014);
    send(BC, "R7");
    reg_wr(8'h00, 32'h0000_0010);
    send(BC, "R7");
    // R8 multicast
    reg_wr(8'h00, 32'h0000_0012);
    send(48'h0100_5E00_00FB, "R8");
    send(BC, "R8");
    reg_wr(8'h00, 32'h0000_0010);
    send(48'h0100_5E00_00FB, "R8");
    // R9 unicast
    reg_wr(8'h00, 32'h0000_0011);
    send(48'h06AA_BBCC_DDEE, "R9");
    send(48'h0100_5E00_00FB, "R9");
    // R10 inverted table term
    reg_wr(8'h00, 32'h0000_0018);
    send(48'h0211_2233_4455, "R10");
    send(48'h06AA_BBCC_DDEE, "R10");
    reg_wr(8'h00, 32'h0000_001C);
    send(BC, "R10");
    // R6 compare-enable clear
    reg_wr(8'h00, 32'h0000_000F);
    send(BC, "R6");
    send(48'h06AA_BBCC_DDEE, "R6");
    send(48'h0211_2233_4455, "R6");
    // R11 write in the cycle of the frame
    reg_wr(8'h00, 32'h0000_0010);
    send_and_write(48'h0211_2233_4455, 8'h04, 32'h0000_0000, "R11");
    send(48'h0211_2233_4455, "R11");
    // R12 out-of-range and misaligned writes
    reg_wr(8'h08, 32'h0A0B_0C0D);
    reg_wr(8'h0C, 32'h0E0F_0000);
    reg_wr(8'h04, 32'h0000_0001);
    reg_wr(8'h88, 32'hDEAD_BEEF);
    reg_wr(8'h8C, 32'hDEAD_BEEF);
    reg_wr(8'h0A, 32'h1111_1111);
    reg_wr(8'h01, 32'h0000_0000);
    send(48'h0A0B_0C0D_0E0F, "R12");
    send(48'hDEAD_BEEF_DEAD, "R12");
    idle(4);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: actual=%0d pending expected=0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule